// File: doc/BRIEF.md
# Serial ADC Output Frame Sequencer

This block is the digital side of a 10-bit successive-approximation converter that a host reads over a three-wire, read-only serial port. The port has an active-low select, a serial clock and a data line. The block watches the select and serial clock lines and runs the conversion frame from them. Each frame has a sample window, one low null bit, the result sent most significant bit first, then the same word sent back least significant bit first, and finally zero padding for as long as the host keeps clocking.

A stand-in for the analog core supplies the conversion value as a parallel word. The block also drives a sample-hold strobe for that core and a low-power flag that models the comparator and bias being switched off while data is shifted out. The data line is given as a value plus a separate output enable, so that the pad can be put into high impedance.

The select and serial clock pins are sampled on the block's own clock, which must run well above the serial clock. Every output is a function of registered state. An output therefore responds within two block-clock cycles of the pin edge that causes it.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, a select line that is already low starts no frame. The output enable stays low and `standby` stays high until the select line has gone high and then low again.
- R2: `hold` rises after the first rising serial-clock edge that follows a falling select edge. It stays high across the first falling edge and the second rising edge, and drops after the second falling edge.
- R3: The output enable stays low for the first two rising edges of a frame. At the second falling edge it rises, and the data line carries a single 0 (the null bit), which the host sees at the third rising edge.
- R4: The next ten falling edges put result bits 9 down to 0 on the data line, one bit per edge.
- R5: While the output is enabled, the data line changes only after a falling serial-clock edge. A host sampling on rising edges therefore works with the clock idling low or idling high.
- R6: Further falling edges after bit 0 send bits 1 up to 9, in that order. Bit 0 is not sent a second time.
- R7: After the second copy of bit 9, every further falling edge with the select line low gives a 0 on the data line.
- R8: The select line going high at any point ends the frame. On the next block-clock cycle the output enable and `hold` are low and `standby` is high. A later frame runs normally from its beginning.
- R9: The conversion value is captured at the second falling edge. Changes to `conv_value` after that point do not alter the bits sent in that frame.
- R10: `bias_off` rises together with the null bit. It stays high through the end of the frame and through standby, and falls only when a new frame starts with a falling select edge.
- R11: The code is straight binary. The all-zero value 000h and the full-scale value 3FFh are each sent bit for bit in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| conv_value | input | 10 | Conversion result from the analog stand-in |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the data pad (0 = high impedance) |
| hold | output | 1 | Sample-hold strobe, high during the sample window |
| standby | output | 1 | High while no frame is active |
| bias_off | output | 1 | Low-power flag for the comparator and bias |

## Verification
The bench targets the seam between the two bit orders. A design with an off-by-one there would repeat bit 0, or would drop bit 9 before the zeros begin, and the shifted sequence would be caught at each rising edge. The select line is held low through reset to catch a design that treats a low level as a start. Frames are aborted both inside the sample window and in the middle of the data, so that a `hold` or output enable left high, or a frame that resumes where it stopped, is exposed. The input word is flipped after capture to catch a design that reads it live. Frames are run with the clock idling high as well as low, which catches a design that counts the extra falling edge before the first rise.

// File: rtl/adc_frame_seq_pkg.sv
package adc_frame_seq_pkg;

    // Frame phases, in the order a frame walks through them.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,  // select high or not yet armed
        PH_WAIT = 3'd1,  // select low, waiting for the first rising edge
        PH_SAMP = 3'd2,  // sample window
        PH_NULL = 3'd3,  // null bit on the line
        PH_MSB  = 3'd4,  // result, high bit first
        PH_LSB  = 3'd5,  // mirrored result, low bit first
        PH_ZERO = 3'd6   // zero padding
    } phase_e;

    function automatic logic phase_drives(input phase_e p);
        return (p == PH_NULL) || (p == PH_MSB) || (p == PH_LSB) || (p == PH_ZERO);
    endfunction

endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
    parameter int             N       = 1,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_d;
    logic [N-1:0] prev_q;

    always_comb begin
        prev_d = pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            assign rise[i] =  pins[i] & ~prev_q[i];
            assign fall[i] = ~pins[i] &  prev_q[i];
        end
    endgenerate

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
    import adc_frame_seq_pkg::*;
#(
    parameter int W  = 10,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    output phase_e        phase,
    output logic [IW-1:0] idx,
    output logic          load,
    output logic          bias_off
);

    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    typedef struct packed {
        phase_e          ph;
        logic [IW-1:0]   idx;
        logic            second;  // first falling edge of the window seen
        logic            lp;      // low-power flag
        logic            cs_prev; // select level on the previous cycle
    } seq_t;

    seq_t r_q;
    seq_t r_d;
    logic cs_fall;

    // cs_prev resets low so a select held low through reset is no edge.
    assign cs_fall = r_q.cs_prev & ~cs_n;

    always_comb begin
        r_d         = r_q;
        r_d.cs_prev = cs_n;
        load        = 1'b0;
        if (cs_n) begin
            r_d.ph = PH_IDLE;
        end else begin
            unique case (r_q.ph)
                PH_IDLE: begin
                    if (cs_fall) begin
                        r_d.ph = PH_WAIT;
                        r_d.lp = 1'b0;
                    end
                end
                PH_WAIT: begin
                    if (sclk_rise) begin
                        r_d.ph     = PH_SAMP;
                        r_d.second = 1'b0;
                    end
                end
                PH_SAMP: begin
                    if (sclk_fall) begin
                        if (r_q.second) begin
                            r_d.ph = PH_NULL;
                            r_d.lp = 1'b1;
                            load   = 1'b1;
                        end else begin
                            r_d.second = 1'b1;
                        end
                    end
                end
                PH_NULL: begin
                    if (sclk_fall) begin
                        r_d.ph  = PH_MSB;
                        r_d.idx = TOP_IDX;
                    end
                end
                PH_MSB: begin
                    if (sclk_fall) begin
                        if (r_q.idx == '0) begin
                            r_d.ph  = PH_LSB;
                            r_d.idx = IW'(1);
                        end else begin
                            r_d.idx = r_q.idx - IW'(1);
                        end
                    end
                end
                PH_LSB: begin
                    if (sclk_fall) begin
                        if (r_q.idx == TOP_IDX) r_d.ph  = PH_ZERO;
                        else                    r_d.idx = r_q.idx + IW'(1);
                    end
                end
                PH_ZERO: begin
                    r_d.ph = PH_ZERO;
                end
                default: begin
                    r_d.ph = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph      <= PH_IDLE;
            r_q.idx     <= '0;
            r_q.second  <= 1'b0;
            r_q.lp      <= 1'b0;
            r_q.cs_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase    = r_q.ph;
    assign idx      = r_q.idx;
    assign bias_off = r_q.lp;

endmodule

// File: rtl/frame_word_out.sv
module frame_word_out
    import adc_frame_seq_pkg::*;
#(
    parameter int W  = 10,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  din,
    input  phase_e        phase,
    input  logic [IW-1:0] idx,
    output logic          sdo,
    output logic          sdo_oe
);

    logic [W-1:0] word_d;
    logic [W-1:0] word_q;

    always_comb begin
        word_d = load ? din : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    // One index serves both bit orders; only the phase says which.
    always_comb begin
        sdo_oe = phase_drives(phase);
        unique case (phase)
            PH_MSB, PH_LSB: sdo = word_q[idx];
            default:        sdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_frame_seq_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic [W-1:0] conv_value,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         hold,
    output logic         standby,
    output logic         bias_off
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic          sclk_rise;
    logic          sclk_fall;
    phase_e        phase;
    logic [IW-1:0] idx;
    logic          load;

    pin_edge_det #(.N(1), .RST_VAL(1'b0)) u_sclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    frame_seq_ctrl #(.W(W), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .phase     (phase),
        .idx       (idx),
        .load      (load),
        .bias_off  (bias_off)
    );

    frame_word_out #(.W(W), .IW(IW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .din    (conv_value),
        .phase  (phase),
        .idx    (idx),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    assign hold    = (phase == PH_SAMP);
    assign standby = (phase == PH_IDLE);

endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic sdo_oe,
    input logic hold,
    input logic standby,
    input logic bias_off
);

    // R8: a high select forces the pad off and standby on the next cycle
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && !hold && standby));

    // R2: the window opens only after a rising serial-clock edge
    assert_hold_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> ($past(sclk) && !$past(sclk, 2)));

    // R3: the pad turns on straight out of the window, with a low null bit
    assert_null_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (!sdo && $past(hold)));

    // R5: driven data moves only after a falling serial-clock edge
    assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> (!$past(sclk) && $past(sclk, 2)));

    // R10: the low-power flag clears only on a falling select edge
    assert_lp_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bias_off) |-> (!$past(cs_n) && $past(cs_n, 2)));

    // R8: sampling and driving never overlap, and standby excludes both
    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold, sdo_oe, standby}));

endmodule

bind adc_frame_seq adc_frame_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .hold     (hold),
    .standby  (standby),
    .bias_off (bias_off)
);

// File: tb/tb_adc_frame_seq.sv
module tb_adc_frame_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sclk = 1'b0;
    logic [9:0] conv_value = '0;
    logic       sdo;
    logic       sdo_oe;
    logic       hold;
    logic       standby;
    logic       bias_off;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    typedef struct {
        bit oe;
        bit b;
        int rq;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    adc_frame_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .conv_value (conv_value),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .hold       (hold),
        .standby    (standby),
        .bias_off   (bias_off)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: compare the line at every rising serial-clock edge.
    always @(posedge sclk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.oe) begin
                chk(sdo_oe === 1'b1, $sformatf("R%0d oe", e.rq), int'(sdo_oe), 1);
                chk(sdo === e.b, $sformatf("R%0d data", e.rq), int'(sdo), int'(e.b));
            end else begin
                chk(sdo_oe === 1'b0, $sformatf("R%0d oe-off", e.rq), int'(sdo_oe), 0);
            end
        end
    end

    // Expected line at rising edge k of a frame (k counts from 1).
    function automatic exp_t expect_at(input int k, input logic [9:0] v);
        exp_t e;
        if (k <= 2) begin
            e.oe = 1'b0; e.b = 1'b0; e.rq = 3;            // R3 silent before null
        end else if (k == 3) begin
            e.oe = 1'b1; e.b = 1'b0; e.rq = 3;            // R3 null bit
        end else if (k <= 13) begin
            e.oe = 1'b1; e.b = v[13 - k]; e.rq = 4;       // R4 high bit first
        end else if (k <= 22) begin
            e.oe = 1'b1; e.b = v[k - 13]; e.rq = 6;       // R6 mirror from bit 1
        end else begin
            e.oe = 1'b1; e.b = 1'b0; e.rq = 7;            // R7 padding
        end
        return e;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nclk serial clocks; idle_hi selects clock idling high.
    task automatic run_frame(input logic [9:0] v, input int nclk, input bit idle_hi, input bit flip);
        conv_value = v;
        sclk = idle_hi;
        wait_n(4);
        cs_n = 1'b0;
        wait_n(4);
        for (int k = 1; k <= nclk; k++) begin
            if (flip && k == 6) conv_value = ~v;  // R9 change after capture
            sb.push_back(expect_at(k, v));
            if (idle_hi) begin
                sclk = 1'b0; wait_n(4);
                sclk = 1'b1; wait_n(4);
            end else begin
                sclk = 1'b1; wait_n(4);
                sclk = 1'b0; wait_n(4);
            end
        end
        cs_n = 1'b1;
        wait_n(3);
        chk(sdo_oe == 1'b0, "R8 oe after end", int'(sdo_oe), 0);
        chk(standby == 1'b1, "R8 standby after end", int'(standby), 1);
        chk(hold == 1'b0, "R8 hold after end", int'(hold), 0);
        chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_sim();
        end
    end

    initial begin
        // Select held low through reset (R1).
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk(sdo_oe == 1'b0, "reset oe", int'(sdo_oe), 0);
        chk(hold == 1'b0, "reset hold", int'(hold), 0);
        chk(standby == 1'b1, "reset standby", int'(standby), 1);
        chk(bias_off == 1'b0, "reset bias_off", int'(bias_off), 0);

        // R1: clocks with select low since power-up start nothing.
        conv_value = 10'h3A5;
        for (int k = 1; k <= 14; k++) begin
            exp_t e;
            e.oe = 1'b0; e.b = 1'b0; e.rq = 1;
            sb.push_back(e);
            sclk = 1'b1; wait_n(4);
            chk(hold == 1'b0, "R1 no sampling", int'(hold), 0);
            sclk = 1'b0; wait_n(4);
        end
        chk(standby == 1'b1, "R1 still standby", int'(standby), 1);
        cs_n = 1'b1;
        wait_n(4);

        // R2, R3, R10: walk through the window by hand.
        cs_n = 1'b0; wait_n(4);
        chk(hold == 1'b0, "R2 hold before first rise", int'(hold), 0);
        sclk = 1'b1; wait_n(4);
        chk(hold == 1'b1, "R2 hold after first rise", int'(hold), 1);
        sclk = 1'b0; wait_n(4);
        chk(hold == 1'b1, "R2 hold after first fall", int'(hold), 1);
        sclk = 1'b1; wait_n(4);
        chk(hold == 1'b1, "R2 hold after second rise", int'(hold), 1);
        chk(sdo_oe == 1'b0, "R3 pad off in window", int'(sdo_oe), 0);
        sclk = 1'b0; wait_n(4);
        chk(hold == 1'b0, "R2 hold after second fall", int'(hold), 0);
        chk(sdo_oe == 1'b1, "R3 pad on", int'(sdo_oe), 1);
        chk(sdo == 1'b0, "R3 null bit", int'(sdo), 0);
        chk(bias_off == 1'b1, "R10 flag set", int'(bias_off), 1);
        cs_n = 1'b1; wait_n(4);
        chk(bias_off == 1'b1, "R10 flag kept in standby", int'(bias_off), 1);
        cs_n = 1'b0; wait_n(3);
        chk(bias_off == 1'b0, "R10 flag cleared by new frame", int'(bias_off), 0);

        // R8: abort inside the sample window.
        sclk = 1'b1; wait_n(4);
        chk(hold == 1'b1, "R8 window open", int'(hold), 1);
        cs_n = 1'b1; wait_n(2);
        chk(hold == 1'b0, "R8 hold dropped", int'(hold), 0);
        chk(standby == 1'b1, "R8 standby", int'(standby), 1);
        sclk = 1'b0; wait_n(4);

        // R4, R6, R7, R9: full frame with the input flipped mid-frame.
        run_frame(10'h2C5, 30, 1'b0, 1'b1);
        // R11: extremes, one with the clock idling high (R5).
        run_frame(10'h3FF, 25, 1'b1, 1'b0);
        run_frame(10'h000, 16, 1'b0, 1'b0);
        // R8: abort mid-data, then a fresh frame from the start.
        run_frame(10'h155, 8, 1'b0, 1'b0);
        run_frame(10'h0F0, 23, 1'b1, 1'b0);
        run_frame(10'h201, 13, 1'b0, 1'b1);

        done = 1'b1;
        finish_sim();
    end

endmodule